// File: doc/BRIEF.md
# NAND Command Sub-cycle Controller

This block gives a CPU a byte-wide command/address port into a NAND flash device, together with a status register. The flash pins are shared with a NOR controller, and the NOR controller always has priority on them. When software writes a byte to the command port, the block asks the shared-bus arbiter for the pins. Once it holds the grant, it raises the command-latch or the address-latch line, chosen by a mode input. It then drives the byte and pulses write-enable low for a fixed number of clocks. It holds the lines for a short time and then releases the bus.

The status register has four live bits:

- A synchronized copy of the device ready/busy pin.
- A controller-busy flag.
- A sticky completion flag.
- A sticky "distracted" flag. It records that the NOR side took the pins while the NAND chip enable was low. Software uses it to know that it must restart the open NAND transaction.

Both sticky flags are cleared by writing 1 to them. Both the port and the status register can be reached from the memory window and from the I/O window.

Top module: `nand_cmd_port`

## Requirements
- R1: The command port decodes at every odd memory offset from 0x801 to 0x80F and at I/O offset 0x05. The status register decodes at memory offset 0x810 and at I/O offset 0x06. Any other offset reads 0x00, and a write to it has no effect.
- R2: While the controller is idle, a write to the command port stores the byte and starts one sub-cycle. A read of the port returns the last stored byte. The port reads 0x00 after reset.
- R3: A write to the command port while the busy bit is set is ignored. The stored byte does not change and no second sub-cycle runs.
- R4: A sub-cycle raises `req_o` and waits for `gnt_i`. It then asserts `cle_o` (when `mode_ale_i`=0 at the write) or `ale_o` (when `mode_ale_i`=1) and drives the byte on `io_o` with `io_oe_o` high. This setup lasts at least one clock before write-enable falls.
- R5: `we_no` stays low for exactly WE_CYCLES clocks. The latch line and the byte are then held for HOLD_CYCLES clocks with `we_no` high. After that the latch line, `io_oe_o` and `req_o` drop.
- R6: If the grant is withdrawn before write-enable falls, the sequence goes back to waiting for the grant. `we_no` does not fall until the grant has been present for a setup clock.
- R7: Status bit 2 (busy) reads 1 from the clock after an accepted write until the sequence has returned to idle.
- R8: Status bit 1 (complete) is set on the clock on which a sub-cycle finishes. Writing 1 to bit 1 clears it, and writing 0 leaves it unchanged.
- R9: Status bit 0 (distracted) is set when `nor_gnt_i` is high while `nand_ce_ni` is low. Writing 1 to bit 0 clears it, and writing 0 leaves it unchanged. `nor_gnt_i` with `nand_ce_ni` high leaves it unchanged.
- R10: When a set event and a write-1 clear reach a sticky status bit on the same clock, the bit stays set.
- R11: Status bit 3 reflects `flash_rdy_i` through two flops. A change becomes visible after the second rising clock edge.
- R12: Status bits 7:4 always read 0. The status register reads 0x00 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_req_i | input | 1 | CPU access strobe, one clock per access |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_io_space_i | input | 1 | 1 = I/O window, 0 = memory window |
| bus_addr_i | input | 12 | Offset within the selected window |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data (combinational from the address) |
| flash_rdy_i | input | 1 | Asynchronous device ready/busy pin |
| nand_ce_ni | input | 1 | NAND chip-enable level; low means a transaction is open |
| nor_gnt_i | input | 1 | NOR controller currently owns the shared pins |
| mode_ale_i | input | 1 | Latch select captured at the write: 0 = command, 1 = address |
| gnt_i | input | 1 | Grant of the shared pins to this block |
| req_o | output | 1 | Request for the shared pins |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| we_no | output | 1 | Active-low write enable |
| io_o | output | 8 | Flash I/O bus byte |
| io_oe_o | output | 1 | Output enable for `io_o` |

## Verification
The hardest case to reach from the ports is a grant that is withdrawn in the single setup clock before write-enable falls. The other hard cases are a write to the port while a sub-cycle is stalled, and a write-1 clear that lands on the same clock as a set event.

The bench models a NOR grant stealer. It drops the grant on random clocks while seeded random bytes and latch modes are issued, so setup-clock withdrawals happen many times. Directed phases hold the stealer active to freeze a sub-cycle in its wait state while a second write is attempted. They also keep the NOR grant and chip enable asserted while the distracted bit is written with 1.

// File: rtl/nand_pkg.sv
package nand_pkg;
  localparam int DW = 8;
  localparam int AW = 12;

  localparam int STS_RDY  = 3;
  localparam int STS_BUSY = 2;
  localparam int STS_DONE = 1;
  localparam int STS_DIST = 0;
  localparam int N_STICKY = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_REL
  } seq_st_e;
endpackage

// File: rtl/nand_addr_dec.sv
module nand_addr_dec
  import nand_pkg::*;
#(
  parameter logic [AW-1:0] MEM_PORT_BASE = 12'h800,
  parameter logic [AW-1:0] MEM_STS_OFS   = 12'h810,
  parameter logic [AW-1:0] IOS_PORT_OFS  = 12'h005,
  parameter logic [AW-1:0] IOS_STS_OFS   = 12'h006
) (
  input  logic          io_space_i,
  input  logic [AW-1:0] addr_i,
  output logic          sel_port_o,
  output logic          sel_sts_o
);
  logic mem_port, mem_sts;

  // odd offsets inside the 16-byte page of the port base, base itself excluded by the odd rule
  assign mem_port = (addr_i[AW-1:4] == MEM_PORT_BASE[AW-1:4]) && addr_i[0];
  assign mem_sts  = (addr_i == MEM_STS_OFS);

  always_comb begin
    if (io_space_i) begin
      sel_port_o = (addr_i == IOS_PORT_OFS);
      sel_sts_o  = (addr_i == IOS_STS_OFS);
    end else begin
      sel_port_o = mem_port;
      sel_sts_o  = mem_sts;
    end
  end
endmodule

// File: rtl/nand_sync.sv
module nand_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/nand_sticky.sv
module nand_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/nand_seq.sv
module nand_seq
  import nand_pkg::*;
#(
  parameter int WE_CYCLES   = 3,
  parameter int HOLD_CYCLES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          mode_ale_i,
  input  logic [DW-1:0] data_i,
  input  logic          gnt_i,
  output logic          req_o,
  output logic          cle_o,
  output logic          ale_o,
  output logic          we_no,
  output logic [DW-1:0] io_o,
  output logic          io_oe_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam int CMAX = (WE_CYCLES > HOLD_CYCLES) ? WE_CYCLES : HOLD_CYCLES;
  localparam int CW   = $clog2(CMAX + 1);

  seq_st_e       st_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] byte_q;
  logic          ale_sel_q;
  logic          drive;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      byte_q    <= '0;
      ale_sel_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q      <= ST_REQ;
          byte_q    <= data_i;
          ale_sel_q <= mode_ale_i;
        end
        ST_REQ: if (gnt_i) st_q <= ST_SETUP;
        ST_SETUP: begin
          if (!gnt_i) st_q <= ST_REQ;
          else begin
            st_q  <= ST_PULSE;
            cnt_q <= CW'(WE_CYCLES - 1);
          end
        end
        ST_PULSE: begin
          if (cnt_q == '0) begin
            st_q  <= ST_HOLD;
            cnt_q <= CW'(HOLD_CYCLES - 1);
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_HOLD: begin
          if (cnt_q == '0) st_q <= ST_REL;
          else cnt_q <= cnt_q - 1'b1;
        end
        ST_REL: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign drive   = (st_q == ST_SETUP) || (st_q == ST_PULSE) || (st_q == ST_HOLD);
  assign req_o   = drive || (st_q == ST_REQ);
  assign cle_o   = drive && !ale_sel_q;
  assign ale_o   = drive && ale_sel_q;
  assign io_oe_o = drive;
  assign io_o    = drive ? byte_q : '0;
  assign we_no   = (st_q != ST_PULSE);
  assign busy_o  = (st_q != ST_IDLE);
  assign done_o  = (st_q == ST_REL);
endmodule

// File: rtl/nand_cmd_port.sv
module nand_cmd_port
  import nand_pkg::*;
#(
  parameter int WE_CYCLES   = 3,
  parameter int HOLD_CYCLES = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_req_i,
  input  logic          bus_wr_i,
  input  logic          bus_io_space_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic          flash_rdy_i,
  input  logic          nand_ce_ni,
  input  logic          nor_gnt_i,
  input  logic          mode_ale_i,
  input  logic          gnt_i,
  output logic          req_o,
  output logic          cle_o,
  output logic          ale_o,
  output logic          we_no,
  output logic [DW-1:0] io_o,
  output logic          io_oe_o
);
  logic          sel_port, sel_sts;
  logic          port_wr, sts_wr, start;
  logic          busy, done, sts_rdy;
  logic [DW-1:0] port_q;
  logic [N_STICKY-1:0] stk_set, stk_clr, stk_q;
  logic [DW-1:0] sts_val;

  nand_addr_dec u_dec (
    .io_space_i (bus_io_space_i),
    .addr_i     (bus_addr_i),
    .sel_port_o (sel_port),
    .sel_sts_o  (sel_sts)
  );

  assign port_wr = bus_req_i && bus_wr_i && sel_port;
  assign sts_wr  = bus_req_i && bus_wr_i && sel_sts;
  assign start   = port_wr && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    port_q <= '0;
    else if (start) port_q <= bus_wdata_i;
  end

  nand_seq #(
    .WE_CYCLES   (WE_CYCLES),
    .HOLD_CYCLES (HOLD_CYCLES)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .mode_ale_i (mode_ale_i),
    .data_i     (bus_wdata_i),
    .gnt_i      (gnt_i),
    .req_o      (req_o),
    .cle_o      (cle_o),
    .ale_o      (ale_o),
    .we_no      (we_no),
    .io_o       (io_o),
    .io_oe_o    (io_oe_o),
    .busy_o     (busy),
    .done_o     (done)
  );

  nand_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (flash_rdy_i),
    .q_o    (sts_rdy)
  );

  assign stk_set[STS_DIST] = nor_gnt_i && !nand_ce_ni;
  assign stk_set[STS_DONE] = done;

  for (genvar g = 0; g < N_STICKY; g++) begin : g_sticky
    assign stk_clr[g] = sts_wr && bus_wdata_i[g];
    nand_sticky u_bit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (stk_set[g]),
      .clr_i  (stk_clr[g]),
      .q_o    (stk_q[g])
    );
  end

  always_comb begin
    sts_val           = '0;
    sts_val[STS_RDY]  = sts_rdy;
    sts_val[STS_BUSY] = busy;
    sts_val[STS_DONE] = stk_q[STS_DONE];
    sts_val[STS_DIST] = stk_q[STS_DIST];
  end

  always_comb begin
    if (sel_port)     bus_rdata_o = port_q;
    else if (sel_sts) bus_rdata_o = sts_val;
    else              bus_rdata_o = '0;
  end
endmodule

// File: rtl/nand_cmd_port_chk.sv
module nand_cmd_port_chk
  import nand_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          gnt_i,
  input logic          nor_gnt_i,
  input logic          nand_ce_ni,
  input logic          flash_rdy_i,
  input logic          we_no,
  input logic          cle_o,
  input logic          ale_o,
  input logic          io_oe_o,
  input logic          req_o,
  input logic          busy,
  input logic          done,
  input logic          port_wr,
  input logic [DW-1:0] port_q,
  input logic          sel_sts,
  input logic [N_STICKY-1:0] stk_q,
  input logic          sts_rdy,
  input logic [DW-1:0] bus_rdata_o
);
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  assert_pulse_needs_grant_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_no) |-> $past(gnt_i));

  assert_latch_in_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> ((cle_o ^ ale_o) && io_oe_o && req_o));

  assert_busy_write_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_wr && busy) |=> $stable(port_q));

  assert_done_sets_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> stk_q[STS_DONE]);

  assert_dist_sets_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nor_gnt_i && !nand_ce_ni) |=> stk_q[STS_DIST]);

  assert_rsvd_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_sts |-> (bus_rdata_o[7:4] == 4'h0));

  assert_rdy_latency_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3) |-> (sts_rdy == $past(flash_rdy_i, 2)));

  assert_idle_no_drive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (!req_o && !io_oe_o && we_no));
endmodule

bind nand_cmd_port nand_cmd_port_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .gnt_i       (gnt_i),
  .nor_gnt_i   (nor_gnt_i),
  .nand_ce_ni  (nand_ce_ni),
  .flash_rdy_i (flash_rdy_i),
  .we_no       (we_no),
  .cle_o       (cle_o),
  .ale_o       (ale_o),
  .io_oe_o     (io_oe_o),
  .req_o       (req_o),
  .busy        (busy),
  .done        (done),
  .port_wr     (port_wr),
  .port_q      (port_q),
  .sel_sts     (sel_sts),
  .stk_q       (stk_q),
  .sts_rdy     (sts_rdy),
  .bus_rdata_o (bus_rdata_o)
);

// File: tb/nand_cmd_port_tb.sv
`timescale 1ns/1ps
module nand_cmd_port_tb;
  localparam int WE   = 3;
  localparam int HOLD = 2;

  logic       clk_i = 0, rst_ni = 0;
  logic       bus_req_i = 0, bus_wr_i = 0, bus_io_space_i = 0;
  logic [11:0] bus_addr_i = '0;
  logic [7:0] bus_wdata_i = '0, bus_rdata_o;
  logic       flash_rdy_i = 0, nand_ce_ni = 1, mode_ale_i = 0;
  logic       steal = 0, rand_steal = 0;
  logic       gnt_i, req_o, cle_o, ale_o, we_no, io_oe_o;
  logic [7:0] io_o;

  assign gnt_i = req_o && !steal;

  nand_cmd_port #(.WE_CYCLES(WE), .HOLD_CYCLES(HOLD)) u_dut (
    .clk_i, .rst_ni, .bus_req_i, .bus_wr_i, .bus_io_space_i, .bus_addr_i,
    .bus_wdata_i, .bus_rdata_o, .flash_rdy_i, .nand_ce_ni,
    .nor_gnt_i(steal), .mode_ale_i, .gnt_i, .req_o, .cle_o, .ale_o,
    .we_no, .io_o, .io_oe_o
  );

  always #2.5 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, pulses = 0;
  bit finished = 0;
  logic [7:0] exp_byte = '0;
  logic       exp_ale = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  // NOR grant stealer
  always @(posedge clk_i) if (rand_steal) begin
    #1 steal = ($urandom % 4) == 0;
  end

  // bus waveform monitor
  logic prev_we = 1, prev_gnt = 0;
  int   low_cnt = 0, hold_left = -1;
  always @(negedge clk_i) if (rst_ni) begin
    if (!we_no && prev_we) begin
      check(prev_gnt, "R6 grant before pulse", prev_gnt, 1);
      check(io_o == exp_byte, "R4 byte on bus", io_o, exp_byte);
      check(cle_o == !exp_ale && ale_o == exp_ale, "R4 latch select", {cle_o, ale_o}, {!exp_ale, exp_ale});
    end
    if (!we_no) low_cnt++;
    if (we_no && !prev_we) begin
      check(low_cnt == WE, "R5 pulse width", low_cnt, WE);
      low_cnt = 0;
      pulses++;
      hold_left = HOLD;
    end
    if (hold_left > 0) begin
      check(io_oe_o && io_o == exp_byte && (cle_o ^ ale_o), "R5 hold", io_o, exp_byte);
      hold_left--;
    end else if (hold_left == 0) begin
      check(!io_oe_o && !cle_o && !ale_o && !req_o, "R5 release", {io_oe_o, cle_o, ale_o, req_o}, 0);
      hold_left = -1;
    end
    prev_we  = we_no;
    prev_gnt = gnt_i;
  end

  task automatic bus_write(input bit ios, input logic [11:0] a, input logic [7:0] d);
    @(negedge clk_i);
    bus_req_i = 1; bus_wr_i = 1; bus_io_space_i = ios; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_req_i = 0; bus_wr_i = 0;
  endtask

  task automatic bus_read(input bit ios, input logic [11:0] a, output logic [7:0] d);
    bus_req_i = 1; bus_wr_i = 0; bus_io_space_i = ios; bus_addr_i = a;
    #0.5 d = bus_rdata_o;
    bus_req_i = 0;
  endtask

  task automatic wait_idle(output bit ok);
    logic [7:0] s;
    ok = 0;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk_i);
      bus_read(1, 12'h006, s);
      if (!s[2]) begin ok = 1; break; end
    end
  endtask

  initial begin
    logic [7:0] r;
    bit ok;
    int p0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    bus_read(1, 12'h005, r); check(r == 8'h00, "R2 port reset", r, 0);
    bus_read(0, 12'h810, r); check(r == 8'h00, "R12 status reset", r, 0);

    // R2/R7/R8 basic command, memory window
    exp_byte = 8'hA5; exp_ale = 0; mode_ale_i = 0; p0 = pulses;
    bus_write(0, 12'h803, 8'hA5);
    bus_read(1, 12'h006, r); check(r[2], "R7 busy after write", r, 8'h04);
    wait_idle(ok); check(ok, "R7 busy clears", ok, 1);
    check(pulses == p0 + 1, "R2 one sub-cycle", pulses - p0, 1);
    bus_read(1, 12'h005, r); check(r == 8'hA5, "R1 R2 readback io window", r, 8'hA5);
    bus_read(0, 12'h80F, r); check(r == 8'hA5, "R1 readback odd 80F", r, 8'hA5);
    bus_read(0, 12'h802, r); check(r == 8'h00, "R1 even offset reads 0", r, 0);
    bus_read(1, 12'h006, r); check(r[1], "R8 complete set", r, 8'h02);
    bus_write(1, 12'h006, 8'h00);
    bus_read(1, 12'h006, r); check(r[1], "R8 write 0 keeps", r, 8'h02);
    bus_write(0, 12'h810, 8'h02);
    bus_read(1, 12'h006, r); check(!r[1], "R8 w1c", r, 0);
    check(r[7:4] == 0, "R12 reserved zero", r[7:4], 0);

    // R1 even offset write has no effect
    p0 = pulses;
    bus_write(0, 12'h804, 8'h3C);
    repeat (4) @(negedge clk_i);
    bus_read(1, 12'h005, r); check(r == 8'hA5, "R1 even write ignored", r, 8'hA5);
    check(pulses == p0, "R1 no sub-cycle", pulses - p0, 0);

    // R3/R6 stalled sub-cycle, write while busy
    steal = 1; exp_byte = 8'h5A; exp_ale = 1; mode_ale_i = 1; p0 = pulses;
    bus_write(1, 12'h005, 8'h5A);
    repeat (10) @(negedge clk_i);
    check(pulses == p0 && we_no, "R6 stall without grant", pulses - p0, 0);
    mode_ale_i = 0;
    bus_write(0, 12'h80F, 8'hC3);
    bus_read(1, 12'h005, r); check(r == 8'h5A, "R3 busy write ignored", r, 8'h5A);
    @(negedge clk_i); steal = 0;
    wait_idle(ok); check(ok, "R6 resumes", ok, 1);
    repeat (3) @(negedge clk_i);
    check(pulses == p0 + 1, "R3 single sub-cycle", pulses - p0, 1);

    // R11 ready synchronizer latency
    @(negedge clk_i); flash_rdy_i = 1;
    bus_read(1, 12'h006, r); check(!r[3], "R11 no change before edge", r[3], 0);
    @(negedge clk_i); bus_read(1, 12'h006, r); check(!r[3], "R11 one edge", r[3], 0);
    @(negedge clk_i); bus_read(1, 12'h006, r); check(r[3], "R11 two edges", r[3], 1);
    flash_rdy_i = 0;
    repeat (2) @(negedge clk_i);
    bus_read(1, 12'h006, r); check(!r[3], "R11 fall", r[3], 0);

    // R9/R10 distracted flag
    bus_write(1, 12'h006, 8'h03);
    steal = 1; nand_ce_ni = 1;
    repeat (2) @(negedge clk_i);
    bus_read(1, 12'h006, r); check(!r[0], "R9 ce high no set", r[0], 0);
    nand_ce_ni = 0;
    @(negedge clk_i);
    bus_read(1, 12'h006, r); check(r[0], "R9 set", r[0], 1);
    bus_write(1, 12'h006, 8'h01);
    bus_read(1, 12'h006, r); check(r[0], "R10 set beats clear", r[0], 1);
    steal = 0; nand_ce_ni = 1;
    bus_write(0, 12'h810, 8'h00);
    bus_read(1, 12'h006, r); check(r[0], "R9 write 0 keeps", r[0], 1);
    bus_write(0, 12'h810, 8'h01);
    bus_read(1, 12'h006, r); check(!r[0], "R9 w1c", r[0], 0);

    // random commands under a random grant stealer
    void'($urandom(32'h5EED));
    rand_steal = 1;
    for (int k = 0; k < 40; k++) begin
      logic [7:0] b;
      b = 8'($urandom);
      exp_byte = b; exp_ale = $urandom % 2; mode_ale_i = exp_ale; p0 = pulses;
      if (k % 2) bus_write(1, 12'h005, b);
      else       bus_write(0, 12'h801 | 12'((k % 8) << 1), b);
      wait_idle(ok); check(ok, "R7 idle", ok, 1);
      repeat (3) @(negedge clk_i);
      check(pulses == p0 + 1, "R2 random sub-cycle", pulses - p0, 1);
      bus_read(0, 12'h80B, r); check(r == b, "R2 random readback", r, b);
      bus_read(0, 12'h810, r); check(r[1] && r[7:4] == 0, "R8 R12 random status", r, 8'h02);
      bus_write(1, 12'h006, 8'h02);
    end
    rand_steal = 0;
    @(negedge clk_i); steal = 0;
    finish_run();
  end

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule